// File: doc/BRIEF.md
# Programmable Three-Port Parallel Interface

This block connects a host bus to three 8-bit parallel ports. The host reaches four locations through a 2-bit address, qualified by an active-low chip select and active-low read and write strobes. Port A and the upper half of port C form one group. Port B and the lower half of port C form the other. A single control location accepts two kinds of word. One kind configures the mode and direction of both groups. The other kind sets or clears one port C bit without disturbing the configuration.

Each group runs either as plain I/O (mode 0) or as strobed I/O (mode 1). In mode 1, certain port C lines become handshake lines: a strobe or acknowledge input from the device, a buffer-full status output, and an interrupt request output. Interrupt requests are gated by enable flags, and those flags live in port C latch bits that are reached by the single-bit command. A group A mode code with the high bit set (the bidirectional mode) is accepted, but the block runs that group as mode 0.

All bus strobes are sampled on the rising clock edge. A write takes effect at the edge where chip select and write are both low. Read data is combinational while chip select and read are both low, and is zero otherwise. Side effects of a read occur at the edge that ends the read cycle.

Top module: `ppi_core`

## Requirements
- R1: Address 0 selects port A, 1 port B, 2 port C and 3 the control location. After reset the control location reads 0x9B and every port output enable is 0, so all ports are inputs in mode 0.
- R2: A control write with bit 7 = 1 is a mode word. Its fields are:
  - bits 6..5: group A mode (01 = mode 1).
  - bit 2: group B mode.
  - bit 4: port A direction.
  - bit 3: port C bits 7..4 direction.
  - bit 1: port B direction.
  - bit 0: port C bits 3..0 direction.

  A direction bit of 1 means input (output enable 0). A direction bit of 0 means output (output enable all ones). The word reads back unchanged.
- R3: A control write with bit 7 = 0 writes bit 0 of the word into the port C latch bit selected by bits 3..1. For example, 0x0F sets bit 7 and 0x0E clears it. No other latch bit changes.
- R4: A single-bit command leaves the stored mode word, and its readback, unchanged.
- R5: In mode 0, a port written as output drives its latched value. A port set as input reads the live pin value with no latching.
- R6: Every mode word clears the A, B and C output latches and all handshake flags.
- R7: A group A mode field of 1x runs group A as mode 0. Port C lines follow their direction bits, and writing port A raises no handshake output.
- R8: In mode 1 input on port A, a high-to-low change on PC4 latches the pins of port A and drives PC5 high (buffer full). A read of port A returns the latched byte and drives PC5 low.
- R9: In mode 1, PC3 (the port A interrupt) goes high when the strobe or acknowledge returns high, but only if the enable bit is 1. The enable bit is PC4 latch for input and PC6 latch for output. A read of port A in input mode clears PC3, and a write of port A in output mode clears it.
- R10: In mode 1 output on port A, a write drives PC7 low. A low level on PC6 then drives PC7 high again.
- R11: In mode 1 on port B:
  - PC2 is the strobe or acknowledge input.
  - PC1 is buffer full (active high) in input mode, or the output-full flag (active low) in output mode.
  - PC0 is the interrupt output, enabled by PC2 latch.
- R12: A read of port C returns, for each bit, the driven value where the output enable is 1 and the pin value where it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 2 | Location select |
| wdata | input | 8 | Write data from host |
| rdata | output | 8 | Read data to host, zero when not reading |
| pa_in | input | 8 | Port A pin values |
| pa_out | output | 8 | Port A driven values |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin values |
| pb_out | output | 8 | Port B driven values |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pin values |
| pc_out | output | 8 | Port C driven values |
| pc_oe | output | 8 | Port C output enables |

## Verification
The bench applies several distinct control words: all-output, mixed nibble directions, input on port A, the bidirectional code, and each mode 1 variant. Reading the output enables after each word separates the individual direction and mode fields.

Single-bit commands target the top bit, a middle bit and the enable positions. Readback of the mode word after each command shows whether the configuration was disturbed.

The handshake sequences toggle the strobe lines while the port pins change after the strobe edge. This separates a latched byte from a live pin value, and an enabled interrupt from a disabled one.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
  localparam int BUS_W = 8;
  localparam int PC_W  = 8;
  localparam logic [BUS_W-1:0] CFG_RESET_WORD = 8'h9B;

  typedef struct packed {
    logic a_mode1;
    logic a_in;
    logic cu_in;
    logic b_mode1;
    logic b_in;
    logic cl_in;
  } cfg_t;

  // Mode field 01 is mode 1; 00 and 1x both run as mode 0.
  function automatic cfg_t decode_cfg(input logic [6:0] w);
    cfg_t c;
    c.a_mode1 = (w[6:5] == 2'b01);
    c.a_in    = w[4];
    c.cu_in   = w[3];
    c.b_mode1 = w[2];
    c.b_in    = w[1];
    c.cl_in   = w[0];
    return c;
  endfunction

  function automatic logic [PC_W-1:0] bsr_apply(input logic [PC_W-1:0] pc,
                                                input logic [3:0] cmd);
    logic [PC_W-1:0] r;
    r = pc;
    r[cmd[3:1]] = cmd[0];
    return r;
  endfunction

  function automatic logic [PC_W-1:0] pin_readback(input logic [PC_W-1:0] drv,
                                                   input logic [PC_W-1:0] oe,
                                                   input logic [PC_W-1:0] pin);
    return (drv & oe) | (pin & ~oe);
  endfunction
endpackage

// File: rtl/ppi_hs_chan.sv
module ppi_hs_chan #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode1,
  input  logic          is_in,
  input  logic          clr,
  input  logic          hs_n,
  input  logic [DW-1:0] pin_data,
  input  logic          cpu_wr,
  input  logic          cpu_rd,
  input  logic [DW-1:0] wdata,
  input  logic          inte,
  output logic [DW-1:0] data_q,
  output logic          ibf,
  output logic          obf,
  output logic          intr,
  output logic          hs_fall
);
  logic hs_q;
  logic hs_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) hs_q <= 1'b1;
    else        hs_q <= hs_n;
  end

  assign hs_fall = mode1 & hs_q & ~hs_n;
  assign hs_rise = mode1 & ~hs_q & hs_n;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      data_q <= '0;
      ibf    <= 1'b0;
      obf    <= 1'b0;
      intr   <= 1'b0;
    end else begin
      if (cpu_wr && !(mode1 && is_in)) data_q <= wdata;
      if (mode1 && is_in) begin
        if (hs_fall) begin
          data_q <= pin_data;
          ibf    <= 1'b1;
        end
        if (hs_rise && inte) intr <= 1'b1;
        if (cpu_rd) begin
          ibf  <= 1'b0;
          intr <= 1'b0;
        end
      end else if (mode1) begin
        if (hs_fall) obf <= 1'b0;
        if (hs_rise && inte) intr <= 1'b1;
        if (cpu_wr) begin
          obf  <= 1'b1;
          intr <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/ppi_portc_map.sv
module ppi_portc_map
  import ppi_pkg::*;
(
  input  cfg_t            cfg,
  input  logic [PC_W-1:0] pc_lat,
  input  logic            a_ibf,
  input  logic            a_obf,
  input  logic            a_intr,
  input  logic            b_ibf,
  input  logic            b_obf,
  input  logic            b_intr,
  output logic [PC_W-1:0] pc_out,
  output logic [PC_W-1:0] pc_oe
);
  localparam int HALF = PC_W / 2;

  always_comb begin
    pc_out = pc_lat;
    pc_oe  = {{HALF{~cfg.cu_in}}, {HALF{~cfg.cl_in}}};
    if (cfg.a_mode1) begin
      pc_out[3] = a_intr;
      pc_oe[3]  = 1'b1;
      if (cfg.a_in) begin
        pc_oe[4]  = 1'b0;
        pc_out[5] = a_ibf;
        pc_oe[5]  = 1'b1;
      end else begin
        pc_oe[6]  = 1'b0;
        pc_out[7] = ~a_obf;
        pc_oe[7]  = 1'b1;
      end
    end
    if (cfg.b_mode1) begin
      pc_out[0] = b_intr;
      pc_oe[0]  = 1'b1;
      pc_out[1] = cfg.b_in ? b_ibf : ~b_obf;
      pc_oe[1]  = 1'b1;
      pc_oe[2]  = 1'b0;
    end
  end
endmodule

// File: rtl/ppi_core.sv
module ppi_core
  import ppi_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic [1:0]       addr,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] rdata,
  input  logic [BUS_W-1:0] pa_in,
  output logic [BUS_W-1:0] pa_out,
  output logic [BUS_W-1:0] pa_oe,
  input  logic [BUS_W-1:0] pb_in,
  output logic [BUS_W-1:0] pb_out,
  output logic [BUS_W-1:0] pb_oe,
  input  logic [PC_W-1:0]  pc_in,
  output logic [PC_W-1:0]  pc_out,
  output logic [PC_W-1:0]  pc_oe
);
  logic [BUS_W-1:0] cfg_word;
  logic [PC_W-1:0]  pc_lat;
  cfg_t             cfg;

  // named bus events
  logic wr_ev, rd_ev, ctl_wr, mode_set, bit_cmd;
  logic a_wr, b_wr, c_wr, a_rd, b_rd;
  assign wr_ev    = ~cs_n & ~wr_n;
  assign rd_ev    = ~cs_n & ~rd_n;
  assign ctl_wr   = wr_ev && addr == 2'd3;
  assign mode_set = ctl_wr & wdata[7];
  assign bit_cmd  = ctl_wr & ~wdata[7];
  assign a_wr     = wr_ev && addr == 2'd0;
  assign b_wr     = wr_ev && addr == 2'd1;
  assign c_wr     = wr_ev && addr == 2'd2;
  assign a_rd     = rd_ev && addr == 2'd0;
  assign b_rd     = rd_ev && addr == 2'd1;

  assign cfg = decode_cfg(cfg_word[6:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_word <= CFG_RESET_WORD;
      pc_lat   <= '0;
    end else if (mode_set) begin
      cfg_word <= wdata;
      pc_lat   <= '0;
    end else if (bit_cmd) begin
      pc_lat <= bsr_apply(pc_lat, wdata[3:0]);
    end else if (c_wr) begin
      pc_lat <= wdata;
    end
  end

  // handshake channel wiring
  logic a_hs_n, a_inte, a_ibf, a_obf, a_intr, a_stb_fall;
  logic b_ibf, b_obf, b_intr, b_stb_fall;
  logic [BUS_W-1:0] a_data, b_data;
  assign a_hs_n = cfg.a_in ? pc_in[4] : pc_in[6];
  assign a_inte = cfg.a_in ? pc_lat[4] : pc_lat[6];

  ppi_hs_chan #(.DW(BUS_W)) chan_a_i (
    .clk(clk), .rst_n(rst_n), .mode1(cfg.a_mode1), .is_in(cfg.a_in),
    .clr(mode_set), .hs_n(a_hs_n), .pin_data(pa_in), .cpu_wr(a_wr),
    .cpu_rd(a_rd), .wdata(wdata), .inte(a_inte), .data_q(a_data),
    .ibf(a_ibf), .obf(a_obf), .intr(a_intr), .hs_fall(a_stb_fall)
  );

  ppi_hs_chan #(.DW(BUS_W)) chan_b_i (
    .clk(clk), .rst_n(rst_n), .mode1(cfg.b_mode1), .is_in(cfg.b_in),
    .clr(mode_set), .hs_n(pc_in[2]), .pin_data(pb_in), .cpu_wr(b_wr),
    .cpu_rd(b_rd), .wdata(wdata), .inte(pc_lat[2]), .data_q(b_data),
    .ibf(b_ibf), .obf(b_obf), .intr(b_intr), .hs_fall(b_stb_fall)
  );

  ppi_portc_map map_i (
    .cfg(cfg), .pc_lat(pc_lat),
    .a_ibf(a_ibf), .a_obf(a_obf), .a_intr(a_intr),
    .b_ibf(b_ibf), .b_obf(b_obf), .b_intr(b_intr),
    .pc_out(pc_out), .pc_oe(pc_oe)
  );

  assign pa_out = a_data;
  assign pa_oe  = {BUS_W{~cfg.a_in}};
  assign pb_out = b_data;
  assign pb_oe  = {BUS_W{~cfg.b_in}};

  logic [BUS_W-1:0] rd_mux;
  always_comb begin
    case (addr)
      2'd0:    rd_mux = (cfg.a_in && !cfg.a_mode1) ? pa_in : a_data;
      2'd1:    rd_mux = (cfg.b_in && !cfg.b_mode1) ? pb_in : b_data;
      2'd2:    rd_mux = pin_readback(pc_out, pc_oe, pc_in);
      default: rd_mux = cfg_word;
    endcase
  end
  assign rdata = rd_ev ? rd_mux : '0;
endmodule

// File: rtl/ppi_core_chk.sv
module ppi_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mode_set,
  input logic       bit_cmd,
  input logic       a_wr,
  input logic [7:0] cfg_word,
  input logic [7:0] pc_lat,
  input logic [7:0] pa_out,
  input logic [7:0] pb_out,
  input logic       a_mode1,
  input logic       a_in,
  input logic       a_stb_fall,
  input logic       a_intr,
  input logic       a_inte,
  input logic       ibf_a_pin,
  input logic       obf_a_pin,
  input logic       pc3_oe
);
  AST_BIT_CMD_KEEPS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cmd |=> cfg_word == $past(cfg_word)); // R4
  AST_BIT_CMD_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cmd |=> $countones(pc_lat ^ $past(pc_lat)) <= 1); // R3
  AST_MODE_SET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    mode_set |=> (pc_lat == 8'h00 && pa_out == 8'h00 && pb_out == 8'h00)); // R6
  AST_IBF_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (a_mode1 && a_in && a_stb_fall && !mode_set) |=> ibf_a_pin); // R8
  AST_INTR_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(a_intr) |-> $past(a_inte)); // R9
  AST_OBF_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (a_mode1 && !a_in && a_wr && !mode_set) |=> !obf_a_pin); // R10
  AST_MODE2_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_word[6] |-> pc3_oe == ~cfg_word[0]); // R7
endmodule

bind ppi_core ppi_core_chk chk_i (
  .clk(clk), .rst_n(rst_n), .mode_set(mode_set), .bit_cmd(bit_cmd),
  .a_wr(a_wr), .cfg_word(cfg_word), .pc_lat(pc_lat), .pa_out(pa_out),
  .pb_out(pb_out), .a_mode1(cfg.a_mode1), .a_in(cfg.a_in),
  .a_stb_fall(a_stb_fall), .a_intr(a_intr), .a_inte(a_inte),
  .ibf_a_pin(pc_out[5]), .obf_a_pin(pc_out[7]), .pc3_oe(pc_oe[3])
);

// File: tb/ppi_core_tb_top.sv
module ppi_core_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata, pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
  logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'hFF;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ppi_core dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0; addr = a; wdata = d;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 pa_oe after reset", pa_oe, 8'h00);
    chk("R1 pb_oe after reset", pb_oe, 8'h00);
    chk("R1 pc_oe after reset", pc_oe, 8'h00);
    bus_rd(2'd3, d);
    chk("R1 control readback after reset", d, 8'h9B);
  endtask

  task automatic t_mode0();
    logic [7:0] d;
    bus_wr(2'd3, 8'h82);
    settle();
    chk("R2 0x82 pa_oe", pa_oe, 8'hFF);
    chk("R2 0x82 pb_oe", pb_oe, 8'h00);
    chk("R2 0x82 pc_oe", pc_oe, 8'hFF);
    bus_rd(2'd3, d);
    chk("R2 mode word readback", d, 8'h82);
    bus_wr(2'd0, 8'h5A);
    settle();
    chk("R5 port A latched output", pa_out, 8'h5A);
    bus_rd(2'd0, d);
    chk("R1 read port A", d, 8'h5A);
    pb_in = 8'h3E;
    bus_rd(2'd1, d);
    chk("R5 port B input live", d, 8'h3E);
    pb_in = 8'hC1;
    bus_rd(2'd1, d);
    chk("R5 port B input unlatched", d, 8'hC1);
    bus_wr(2'd3, 8'h88);
    settle();
    chk("R2 0x88 pc_oe split", pc_oe, 8'h0F);
    pc_in = 8'hA0;
    bus_wr(2'd2, 8'h03);
    bus_rd(2'd2, d);
    chk("R12 port C mixed readback", d, 8'hA3);
    pc_in = 8'hFF;
  endtask

  task automatic t_bit_cmd();
    logic [7:0] d;
    bus_wr(2'd3, 8'h80);
    bus_wr(2'd3, 8'h0F);
    settle();
    chk("R3 set bit 7", pc_out, 8'h80);
    bus_wr(2'd3, 8'h07);
    settle();
    chk("R3 set bit 3", pc_out, 8'h88);
    bus_wr(2'd3, 8'h0E);
    settle();
    chk("R3 clear bit 7", pc_out, 8'h08);
    bus_rd(2'd3, d);
    chk("R4 mode word kept", d, 8'h80);
    chk("R4 pa_oe kept", pa_oe, 8'hFF);
  endtask

  task automatic t_clear();
    bus_wr(2'd0, 8'h33);
    bus_wr(2'd1, 8'h44);
    bus_wr(2'd3, 8'h80);
    settle();
    chk("R6 port A cleared", pa_out, 8'h00);
    chk("R6 port B cleared", pb_out, 8'h00);
    chk("R6 port C cleared", pc_out, 8'h00);
  endtask

  task automatic t_mode2();
    bus_wr(2'd3, 8'hC0);
    settle();
    chk("R7 pc_oe all out", pc_oe, 8'hFF);
    bus_wr(2'd0, 8'h11);
    settle();
    chk("R7 port A written", pa_out, 8'h11);
    chk("R7 no handshake on C", pc_out, 8'h00);
  endtask

  task automatic t_a_in();
    logic [7:0] d;
    bus_wr(2'd3, 8'hB0);
    settle();
    chk("R8 pc_oe in mode 1 input", pc_oe, 8'hEF);
    bus_wr(2'd3, 8'h09);
    pa_in = 8'h3C;
    @(negedge clk); pc_in[4] = 1'b0;
    settle();
    chk("R8 PC5 buffer full", {7'd0, pc_out[5]}, 8'h01);
    chk("R9 PC3 low before strobe end", {7'd0, pc_out[3]}, 8'h00);
    pa_in = 8'h00;
    @(negedge clk); pc_in[4] = 1'b1;
    settle();
    chk("R9 PC3 high after strobe end", {7'd0, pc_out[3]}, 8'h01);
    bus_rd(2'd0, d);
    chk("R8 latched byte", d, 8'h3C);
    settle();
    chk("R8 PC5 cleared by read", {7'd0, pc_out[5]}, 8'h00);
    chk("R9 PC3 cleared by read", {7'd0, pc_out[3]}, 8'h00);
    bus_wr(2'd3, 8'h08);
    @(negedge clk); pc_in[4] = 1'b0;
    @(negedge clk); pc_in[4] = 1'b1;
    settle();
    chk("R9 no interrupt when disabled", {7'd0, pc_out[3]}, 8'h00);
    chk("R8 PC5 set with enable off", {7'd0, pc_out[5]}, 8'h01);
    bus_rd(2'd0, d);
  endtask

  task automatic t_a_out();
    bus_wr(2'd3, 8'hA0);
    settle();
    chk("R10 PC7 high after mode word", {7'd0, pc_out[7]}, 8'h01);
    bus_wr(2'd3, 8'h0D);
    bus_wr(2'd0, 8'h77);
    settle();
    chk("R10 port A out", pa_out, 8'h77);
    chk("R10 PC7 low after write", {7'd0, pc_out[7]}, 8'h00);
    @(negedge clk); pc_in[6] = 1'b0;
    settle();
    chk("R10 PC7 high after ack", {7'd0, pc_out[7]}, 8'h01);
    chk("R9 PC3 low during ack", {7'd0, pc_out[3]}, 8'h00);
    @(negedge clk); pc_in[6] = 1'b1;
    settle();
    chk("R9 PC3 high after ack", {7'd0, pc_out[3]}, 8'h01);
    bus_wr(2'd0, 8'h78);
    settle();
    chk("R9 PC3 cleared by write", {7'd0, pc_out[3]}, 8'h00);
  endtask

  task automatic t_b();
    logic [7:0] d;
    bus_wr(2'd3, 8'h86);
    bus_wr(2'd3, 8'h05);
    settle();
    chk("R11 PC2 input", {7'd0, pc_oe[2]}, 8'h00);
    pb_in = 8'hC3;
    @(negedge clk); pc_in[2] = 1'b0;
    settle();
    chk("R11 PC1 buffer full", {7'd0, pc_out[1]}, 8'h01);
    pb_in = 8'h00;
    @(negedge clk); pc_in[2] = 1'b1;
    settle();
    chk("R11 PC0 interrupt", {7'd0, pc_out[0]}, 8'h01);
    bus_rd(2'd1, d);
    chk("R11 port B latched byte", d, 8'hC3);
    settle();
    chk("R11 PC1 PC0 cleared", {6'd0, pc_out[1:0]}, 8'h00);
    bus_wr(2'd3, 8'h84);
    bus_wr(2'd1, 8'h05);
    settle();
    chk("R11 PC1 output full low", {7'd0, pc_out[1]}, 8'h00);
    chk("R11 port B out", pb_out, 8'h05);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    t_reset();
    t_mode0();
    t_bit_cmd();
    t_clear();
    t_mode2();
    t_a_in();
    t_a_out();
    t_b();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule